// File: doc/BRIEF.md
# Flash Block Write-Protection Gate

This block sits in front of the program and erase engine of a flash array of 16 equal blocks. Each request names a target block. The gate decides whether the request may go ahead or must be dropped without any report. Three inputs take part in the decision. The first is a per-block software lock vector. The second is an active-low pin that guards only the top block, block 15. The third is an active-low pin that guards every main block, blocks 0 to 14. A pin held low overrides the lock vector for the blocks it covers. A pin held high hands the decision to the lock vector.

A granted request starts an operation. The gate stores both pin levels when it accepts the request and holds them until the engine signals the end of the operation. The two pins must not move while an operation runs. If either pin differs from its stored level during an operation, a sticky misuse flag goes high and stays high until reset. A refused request makes a one-cycle ignore pulse and nothing else: it issues no write strobe and starts no operation.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset, grant_o, wr_stb_o, ignore_o, busy_o and misuse_o are all low.
- R2: While top_lock_ni is low, a request to block 15 is refused whatever lock_bits_i[15] holds.
- R3: While top_lock_ni is high, a request to block 15 is granted when lock_bits_i[15] is 0 and refused when it is 1.
- R4: top_lock_ni has no influence on requests to blocks 0 to 14.
- R5: While wr_prot_ni is low, a request to any of blocks 0 to 14 is refused whatever its lock bit holds.
- R6: While wr_prot_ni is high, a request to block b in 0 to 14 follows lock_bits_i[b], where 1 means locked. wr_prot_ni has no influence on block 15.
- R7: A request is accepted on the clock edge where req_i is high and busy_o is low. In the cycle after that edge, a grant raises grant_o and wr_stb_o for exactly one cycle, and a refusal raises ignore_o for exactly one cycle. grant_o and ignore_o are never high together.
- R8: After a grant, busy_o is high from the next cycle until the edge where op_done_i is sampled high. A refusal leaves busy_o low.
- R9: A request made while busy_o is high is discarded: it produces no grant_o, no wr_stb_o and no ignore_o.
- R10: While busy_o is high, any difference between a pin and its level stored at acceptance sets misuse_o on the next edge. misuse_o then stays high until reset. Pin changes while busy_o is low do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Program/erase request strobe |
| blk_i | input | 4 | Target block number |
| lock_bits_i | input | 16 | Software lock per block, 1 = locked |
| top_lock_ni | input | 1 | Top-block lock pin, active low |
| wr_prot_ni | input | 1 | Main-block write-protect pin, active low |
| op_done_i | input | 1 | Engine signals end of running operation |
| grant_o | output | 1 | Request granted (one-cycle pulse) |
| wr_stb_o | output | 1 | Write strobe to the engine (one-cycle pulse) |
| ignore_o | output | 1 | Request silently refused (one-cycle pulse) |
| busy_o | output | 1 | Granted operation in flight |
| misuse_o | output | 1 | Sticky flag: a pin moved during an operation |

## Verification
A protection mask bit that is wrong for some block shows up one cycle after a request to that block, as a swapped grant_o/ignore_o pair. The directed tests therefore sweep every block under each pin combination. A busy state that is lost or stuck shows up when the next request arrives: a second request gets an answer when it should not, or the first request after op_done_i gets none. Stored pin levels that are wrong are visible only through misuse_o. The bench therefore toggles each pin both inside and outside an operation and reads the flag one cycle later.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef struct packed {
    logic top_n;
    logic wp_n;
  } pin_cap_t;
endpackage

// File: rtl/wp_prot_mask.sv
module wp_prot_mask #(
  parameter int NUM_BLOCKS = 16
) (
  input  logic [NUM_BLOCKS-1:0] lock_bits_i,
  input  logic                  top_lock_ni,
  input  logic                  wr_prot_ni,
  output logic [NUM_BLOCKS-1:0] prot_o
);
  localparam int TOP_BLK = NUM_BLOCKS - 1;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    if (b == TOP_BLK) begin : g_top
      assign prot_o[b] = ~top_lock_ni | lock_bits_i[b];
    end else begin : g_main
      assign prot_o[b] = ~wr_prot_ni | lock_bits_i[b];
    end
  end
endmodule

// File: rtl/wp_op_track.sv
module wp_op_track
  import flash_wp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     done_i,
  input  pin_cap_t pins_i,
  output logic     busy_o,
  output logic     misuse_o
);
  logic     busy_q, misuse_q;
  pin_cap_t cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cap_q    <= '1;
      misuse_q <= 1'b0;
    end else begin
      if (busy_q && done_i)     busy_q <= 1'b0;
      else if (start_i)         busy_q <= 1'b1;
      if (start_i && !busy_q)   cap_q  <= pins_i;
      if (busy_q && (pins_i != cap_q)) misuse_q <= 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign misuse_o = misuse_q;

  // R10
  misuse_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misuse_q |=> misuse_q);
  // R10
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(cap_q));
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [BLK_W-1:0]      blk_i,
  input  logic [NUM_BLOCKS-1:0] lock_bits_i,
  input  logic                  top_lock_ni,
  input  logic                  wr_prot_ni,
  input  logic                  op_done_i,
  output logic                  grant_o,
  output logic                  wr_stb_o,
  output logic                  ignore_o,
  output logic                  busy_o,
  output logic                  misuse_o
);
  localparam logic [BLK_W-1:0] TOP_BLK = BLK_W'(NUM_BLOCKS - 1);

  logic [NUM_BLOCKS-1:0] prot;
  logic                  accept, allow, busy;
  logic                  grant_q, ign_q;
  pin_cap_t              pins;

  assign pins = '{top_n: top_lock_ni, wp_n: wr_prot_ni};

  wp_prot_mask #(.NUM_BLOCKS(NUM_BLOCKS)) u_mask (
    .lock_bits_i (lock_bits_i),
    .top_lock_ni (top_lock_ni),
    .wr_prot_ni  (wr_prot_ni),
    .prot_o      (prot)
  );

  assign accept = req_i & ~busy;
  assign allow  = ~prot[blk_i];

  wp_op_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept & allow),
    .done_i   (op_done_i),
    .pins_i   (pins),
    .busy_o   (busy),
    .misuse_o (misuse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      ign_q   <= 1'b0;
    end else begin
      grant_q <= accept & allow;
      ign_q   <= accept & ~allow;
    end
  end

  assign grant_o  = grant_q;
  assign wr_stb_o = grant_q;
  assign ignore_o = ign_q;
  assign busy_o   = busy;

  // R7
  grant_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_q, ign_q}));
  // R8
  grant_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q |-> busy);
  // R2
  top_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy && blk_i == TOP_BLK && !top_lock_ni) |=> (ign_q && !grant_q));
  // R5
  wp_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy && blk_i != TOP_BLK && !wr_prot_ni) |=> (ign_q && !grant_q));
  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy && !op_done_i) |=> (!grant_q && !ign_q));
endmodule

// File: tb/flash_wp_gate_tb.sv
module flash_wp_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  blk = '0;
  logic [15:0] lock = '0;
  logic        top_n = 1'b1;
  logic        wp_n = 1'b1;
  logic        done = 1'b0;
  logic        grant, stb, ign, busy, misuse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .blk_i(blk), .lock_bits_i(lock),
    .top_lock_ni(top_n), .wr_prot_ni(wp_n), .op_done_i(done),
    .grant_o(grant), .wr_stb_o(stb), .ignore_o(ign), .busy_o(busy), .misuse_o(misuse)
  );

  task automatic chk(input string req_tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (grant,stb,ign,busy,misuse)", req_tag, act, exp);
    end
  endtask

  function automatic logic allowed(input logic [3:0] b);
    if (b == 4'd15) return top_n && !lock[15];
    return wp_n && !lock[b];
  endfunction

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue request; check decision cycle and pulse end; close the op if granted
  task automatic request(input string tag, input logic [3:0] b);
    logic ok;
    ok = allowed(b);
    req = 1'b1; blk = b;
    @(negedge clk);
    req = 1'b0;
    chk(tag, {grant, stb, ign, busy, misuse}, {ok, ok, !ok, ok, 1'b0});
    @(negedge clk);
    chk(tag, {grant, stb, ign, busy, misuse}, {1'b0, 1'b0, 1'b0, ok, 1'b0});
    if (ok) begin
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk(tag, {grant, stb, ign, busy, misuse}, 5'b0);
    end
  endtask

  task automatic t_reset;
    // R1
    chk("R1", {grant, stb, ign, busy, misuse}, 5'b0);
  endtask

  task automatic t_top_block;
    lock = '0; wp_n = 1'b1;
    top_n = 1'b0; request("R2", 4'd15);
    lock[15] = 1'b1; request("R2", 4'd15);
    top_n = 1'b1; request("R3", 4'd15);
    lock[15] = 1'b0; request("R3", 4'd15);
    // R4: top pin low leaves main blocks granted
    top_n = 1'b0;
    for (int b = 0; b < 15; b++) request("R4", 4'(b));
    top_n = 1'b1;
  endtask

  task automatic t_main_blocks;
    wp_n = 1'b0; lock = '0;
    for (int b = 0; b < 15; b++) request("R5", 4'(b));
    // R6: write-protect does not reach block 15
    request("R6", 4'd15);
    wp_n = 1'b1; lock = 16'h5A3C;
    for (int b = 0; b < 15; b++) request("R6", 4'(b));
    lock = '0;
  endtask

  task automatic t_busy;
    // R8, R9: second request during operation discarded
    req = 1'b1; blk = 4'd2;
    @(negedge clk);
    chk("R7", {grant, stb, ign, busy, misuse}, 5'b11010);
    blk = 4'd15; lock[15] = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R9", {grant, stb, ign, busy, misuse}, 5'b00010);
    cyc_wait(3);
    chk("R8", {grant, stb, ign, busy, misuse}, 5'b00010);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R8", {grant, stb, ign, busy, misuse}, 5'b0);
    lock = '0;
  endtask

  task automatic t_misuse;
    // R10: idle toggles do not flag
    wp_n = 1'b0; @(negedge clk); top_n = 1'b0; @(negedge clk);
    wp_n = 1'b1; top_n = 1'b1; @(negedge clk);
    chk("R10", {grant, stb, ign, busy, misuse}, 5'b0);
    req = 1'b1; blk = 4'd3;
    @(negedge clk);
    req = 1'b0;
    top_n = 1'b0;
    @(negedge clk);
    chk("R10", {grant, stb, ign, busy, misuse}, 5'b00011);
    top_n = 1'b1; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R10", {grant, stb, ign, busy, misuse}, 5'b00001);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1", {grant, stb, ign, busy, misuse}, 5'b0);
    // R10: write-protect pin moving mid-op also flags
    req = 1'b1; blk = 4'd15;
    @(negedge clk);
    req = 1'b0; wp_n = 1'b0;
    @(negedge clk);
    chk("R10", {grant, stb, ign, busy, misuse}, 5'b00011);
    wp_n = 1'b1; done = 1'b1; @(negedge clk); done = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_CYCLES && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    cyc_wait(2);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_top_block();
    t_main_blocks();
    t_busy();
    t_misuse();
    finished = 1;
    summary();
  end
endmodule